// File: doc/BRIEF.md
# Rotate-Shift-Mask Unit

A combinational 64-bit datapath for the fixed-point stage of a processor pipeline. A single left rotator, a mask generator and a merge stage together produce rotate-with-mask, masked insertion into a second operand, logical left and right shifts, arithmetic right shifts with a carry, and a sign-extend-then-shift-left operation. Each of these has a 32-bit and a 64-bit form. The operation is chosen by six mode flags. The mask bounds come from two 5-bit fields of the instruction word.

The unit has no clock, no reset and no state. The result and the carry settle within one cycle of the inputs. Clear-left and clear-right select the masked rotate forms. When both are low, the right-shift and arithmetic flags choose among the three plain shifts. Mask positions use big-endian numbering, so index 0 is bit 63 and index 63 is bit 0. A mask whose begin index is greater than its end index wraps around through both ends.

Top module: `rsm_unit`

## Requirements
- R1: With the 32-bit flag and both clear flags set, the low word of the source is copied into both halves and rotated left by shift bits 4..0. The kept span runs from index 32+insn[10:6] to index 32+insn[5:1].
- R2: When the begin index exceeds the end index, the mask covers the begin index through 63 and also 0 through the end index, so upper result bits follow the rotated copy.
- R3: In 64-bit mode with clear-left alone, the source is rotated left by shift bits 5..0 and indices from the wide index {insn[5], insn[10:6]} through 63 are kept.
- R4: In 64-bit mode with clear-right alone, the rotation is the same and indices 0 through the wide index {insn[5], insn[10:6]} are kept.
- R5: In 64-bit mode with both clear flags set, indices from the wide index through 63 minus shift bits 5..0 are kept.
- R6: For every operation except the arithmetic shift, each result bit outside the mask is taken from the insertion operand.
- R7: With both clear flags low and the right-shift flag low, a logical left shift by the full 7-bit amount is performed. Any amount of at least 32 (32-bit mode) or 64 (64-bit mode) leaves no source bit. In 32-bit mode with a zero insertion operand, result bits 63..32 are zero.
- R8: With the right-shift flag set and the arithmetic flag low, a logical right shift of the low word (32-bit) or of the whole source (64-bit) is performed by the full 7-bit amount, with the same limits as R7.
- R9: With both the right-shift and arithmetic flags set, the shift fills with the sign bit (bit 31 or bit 63). In 32-bit mode, bits 63..32 carry the sign. An amount at or above the width gives all sign bits.
- R10: The carry is 1 only for an arithmetic right shift of a negative source that shifts out at least one 1 bit within the operand width. It is 0 for every other operation.
- R11: With the sign-extend flag set in 64-bit mode, bit 31 of the source is copied into bits 63..32 before the value is shifted left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 64 | Source operand |
| ins_i | input | 64 | Insertion operand, merged outside the mask |
| shamt_i | input | 7 | Shift or rotate amount |
| insn_i | input | 32 | Instruction word, supplies the mask fields |
| word32_i | input | 1 | 32-bit form |
| shr_i | input | 1 | Right shift |
| arith_i | input | 1 | Arithmetic (sign-filling) right shift |
| clr_left_i | input | 1 | Mask from a begin index |
| clr_right_i | input | 1 | Mask up to an end index |
| sext_i | input | 1 | Sign-extend the low word of the source first |
| result_o | output | 64 | Result |
| carry_o | output | 1 | Carry from an arithmetic right shift |

## Verification
An arithmetic right shift produces the sign-filled result and the carry from the same input vector, so both must be right at the same moment. The bench drives negative sources in which 1 bits sit in the shifted-out positions, negative sources in which only 0 bits are lost, and amounts at and beyond the width. Each scoreboard item holds the expected result and carry together, and a single comparison judges both. Wrapping masks combined with a non-zero insertion operand are judged in the same way.

// File: rtl/rsm_pkg.sv
`timescale 1ns/1ps
package rsm_pkg;

    typedef enum logic [2:0] {
        OP_ROTM32,
        OP_KEEP_HI,
        OP_KEEP_LO,
        OP_KEEP_MID,
        OP_SHL,
        OP_SHR,
        OP_SAR
    } rsm_op_e;

    typedef struct packed {
        logic word32;
        logic shr;
        logic arith;
        logic clr_left;
        logic clr_right;
        logic sext;
    } rsm_mode_t;

    function automatic rsm_op_e rsm_decode(input rsm_mode_t m);
        rsm_op_e op;
        if (m.clr_left && m.clr_right)
            op = m.word32 ? OP_ROTM32 : OP_KEEP_MID;
        else if (m.clr_left)
            op = OP_KEEP_HI;
        else if (m.clr_right)
            op = OP_KEEP_LO;
        else if (m.shr)
            op = m.arith ? OP_SAR : OP_SHR;
        else
            op = OP_SHL;
        return op;
    endfunction

endpackage

// File: rtl/rsm_prep.sv
`timescale 1ns/1ps
module rsm_prep #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic              word32_i,
    input  logic              sext_i,
    output logic [DATA_W-1:0] staged_o
);
    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        if (word32_i)
            staged_o = {src_i[HALF_W-1:0], src_i[HALF_W-1:0]};
        else if (sext_i)
            staged_o = {{HALF_W{src_i[HALF_W-1]}}, src_i[HALF_W-1:0]};
        else
            staged_o = src_i;
    end

    always_comb begin
        if (!word32_i && sext_i) begin
            AST_SEXT_UPPER: assert (staged_o[DATA_W-1:HALF_W] == {HALF_W{src_i[HALF_W-1]}}); // R11
        end
    end
endmodule

// File: rtl/rsm_rotl.sv
`timescale 1ns/1ps
module rsm_rotl #(
    parameter int DATA_W = 64,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [AMT_W-1:0]  amt_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] stage [AMT_W+1];

    assign stage[0] = data_i;

    for (genvar g = 0; g < AMT_W; g++) begin : g_stage
        localparam int SH = 1 << g;
        assign stage[g+1] = amt_i[g]
            ? {stage[g][DATA_W-1-SH:0], stage[g][DATA_W-1 -: SH]}
            : stage[g];
    end

    assign data_o = stage[AMT_W];

    always_comb begin
        AST_ROT_ONES_KEPT: assert ($countones(data_o) == $countones(data_i)); // R1
    end
endmodule

// File: rtl/rsm_mask.sv
`timescale 1ns/1ps
module rsm_mask
    import rsm_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int SHAMT_W = 7,
    parameter int IDX_W   = $clog2(DATA_W),
    parameter int FLD_W   = IDX_W - 1
) (
    input  rsm_op_e            op_i,
    input  logic               word32_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  logic [FLD_W-1:0]   beg_f_i,
    input  logic [FLD_W-1:0]   end_f_i,
    output logic [DATA_W-1:0]  mask_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [IDX_W-1:0] TOP_IX  = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] HALF_IX = IDX_W'(HALF_W);

    logic [IDX_W-1:0] wide_ix;
    logic [IDX_W-1:0] amt;
    logic [IDX_W-1:0] lo;
    logic [IDX_W-1:0] hi;
    logic             en;
    logic             over;

    assign wide_ix = {end_f_i[FLD_W-1], beg_f_i};
    assign amt     = shamt_i[IDX_W-1:0];
    assign over    = word32_i ? (shamt_i >= SHAMT_W'(HALF_W))
                              : (shamt_i >= SHAMT_W'(DATA_W));

    always_comb begin
        lo = '0;
        hi = TOP_IX;
        en = 1'b1;
        unique case (op_i)
            OP_ROTM32: begin
                lo = HALF_IX + IDX_W'(beg_f_i);
                hi = HALF_IX + IDX_W'(end_f_i);
            end
            OP_KEEP_HI: begin
                lo = wide_ix;
                hi = TOP_IX;
            end
            OP_KEEP_LO: begin
                lo = '0;
                hi = wide_ix;
            end
            OP_KEEP_MID: begin
                lo = wide_ix;
                hi = TOP_IX - amt;
            end
            OP_SHL: begin
                lo = word32_i ? HALF_IX : '0;
                hi = TOP_IX - amt;
                en = !over;
            end
            OP_SHR, OP_SAR: begin
                lo = (word32_i ? HALF_IX : '0) + amt;
                hi = TOP_IX;
                en = !over;
            end
            default: begin
                en = 1'b0;
            end
        endcase
    end

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
        localparam logic [IDX_W-1:0] BE = IDX_W'(gi);
        assign mask_o[DATA_W-1-gi] = en &&
            ((lo <= hi) ? ((BE >= lo) && (BE <= hi))
                        : ((BE >= lo) || (BE <= hi)));
    end

    always_comb begin
        if (op_i == OP_ROTM32 && beg_f_i > end_f_i) begin
            AST_MASK_WRAP_ENDS: assert (mask_o[DATA_W-1] && mask_o[0]); // R2
        end
        if (op_i == OP_KEEP_HI) begin
            AST_MASK_HI_COUNT: assert ($countones(mask_o) == DATA_W - int'(wide_ix)); // R3
        end
        if (op_i == OP_KEEP_LO) begin
            AST_MASK_LO_TOP: assert (mask_o[DATA_W-1]); // R4
        end
    end
endmodule

// File: rtl/rsm_carry.sv
`timescale 1ns/1ps
module rsm_carry #(
    parameter int DATA_W  = 64,
    parameter int SHAMT_W = 7
) (
    input  logic [DATA_W-1:0]  src_i,
    input  logic               word32_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  logic               active_i,
    output logic               sign_o,
    output logic               carry_o
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] lost;

    assign sign_o = word32_i ? src_i[HALF_W-1] : src_i[DATA_W-1];

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_lost
        localparam bit IN_HALF = (gi < HALF_W);
        assign lost[gi] = src_i[gi] && (IN_HALF || !word32_i) &&
                          (SHAMT_W'(gi) < shamt_i);
    end

    assign carry_o = active_i && sign_o && (|lost);

    always_comb begin
        if (shamt_i == '0) begin
            AST_CARRY_NO_SHIFT: assert (!carry_o); // R10
        end
    end
endmodule

// File: rtl/rsm_unit.sv
`timescale 1ns/1ps
module rsm_unit
    import rsm_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int SHAMT_W = 7,
    parameter int INSN_W  = 32,
    parameter int BEG_LSB = 6,
    parameter int END_LSB = 1
) (
    input  logic [DATA_W-1:0]  src_i,
    input  logic [DATA_W-1:0]  ins_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  logic [INSN_W-1:0]  insn_i,
    input  logic               word32_i,
    input  logic               shr_i,
    input  logic               arith_i,
    input  logic               clr_left_i,
    input  logic               clr_right_i,
    input  logic               sext_i,
    output logic [DATA_W-1:0]  result_o,
    output logic               carry_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int FLD_W  = IDX_W - 1;

    rsm_mode_t         mode;
    rsm_op_e           op;
    logic [FLD_W-1:0]  beg_f;
    logic [FLD_W-1:0]  end_f;
    logic [IDX_W-1:0]  amt_base;
    logic [IDX_W-1:0]  rot_amt;
    logic              go_right;
    logic [DATA_W-1:0] staged;
    logic [DATA_W-1:0] rotated;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] fill;
    logic              sign;
    logic              unused_insn;

    assign mode = '{word32: word32_i, shr: shr_i, arith: arith_i,
                    clr_left: clr_left_i, clr_right: clr_right_i, sext: sext_i};
    assign op   = rsm_decode(mode);

    assign beg_f = insn_i[BEG_LSB +: FLD_W];
    assign end_f = insn_i[END_LSB +: FLD_W];
    assign unused_insn = ^{insn_i[INSN_W-1:BEG_LSB+FLD_W], insn_i[END_LSB-1:0]};

    assign go_right = (op == OP_SHR) || (op == OP_SAR);
    assign amt_base = word32_i ? {1'b0, shamt_i[FLD_W-1:0]} : shamt_i[IDX_W-1:0];
    assign rot_amt  = go_right ? (IDX_W'(0) - amt_base) : amt_base;

    rsm_prep #(.DATA_W(DATA_W)) u_prep (
        .src_i    (src_i),
        .word32_i (word32_i),
        .sext_i   (sext_i),
        .staged_o (staged)
    );

    rsm_rotl #(.DATA_W(DATA_W), .AMT_W(IDX_W)) u_rotl (
        .data_i (staged),
        .amt_i  (rot_amt),
        .data_o (rotated)
    );

    rsm_mask #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .IDX_W(IDX_W), .FLD_W(FLD_W)) u_mask (
        .op_i     (op),
        .word32_i (word32_i),
        .shamt_i  (shamt_i),
        .beg_f_i  (beg_f),
        .end_f_i  (end_f),
        .mask_o   (mask)
    );

    rsm_carry #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_carry (
        .src_i    (src_i),
        .word32_i (word32_i),
        .shamt_i  (shamt_i),
        .active_i (op == OP_SAR),
        .sign_o   (sign),
        .carry_o  (carry_o)
    );

    assign fill     = (op == OP_SAR) ? {DATA_W{sign}} : ins_i;
    assign result_o = (rotated & mask) | (fill & ~mask);

    logic chk_sign;
    logic chk_over;
    assign chk_sign = word32_i ? src_i[HALF_W-1] : src_i[DATA_W-1];
    assign chk_over = word32_i ? (shamt_i >= SHAMT_W'(HALF_W)) : (shamt_i >= SHAMT_W'(DATA_W));

    always_comb begin
        if (!(shr_i && arith_i && !clr_left_i && !clr_right_i)) begin
            AST_CARRY_ONLY_SAR: assert (!carry_o); // R10
        end
        if (carry_o) begin
            AST_CARRY_NEEDS_SIGN: assert (chk_sign); // R10
        end
        if (!clr_left_i && !clr_right_i && !(shr_i && arith_i) && chk_over) begin
            AST_LOGIC_SAT: assert (result_o == ins_i); // R7
        end
        if (!clr_left_i && !clr_right_i && shr_i && arith_i && chk_over) begin
            AST_ARITH_SAT: assert (result_o == {DATA_W{chk_sign}}); // R9
        end
        if (!clr_left_i && !clr_right_i && !(shr_i && arith_i) && word32_i &&
            ins_i[DATA_W-1:HALF_W] == '0) begin
            AST_SHIFT32_UPPER: assert (result_o[DATA_W-1:HALF_W] == '0); // R7
        end
        if (!clr_left_i && !clr_right_i && shr_i && arith_i && word32_i) begin
            AST_SAR32_UPPER: assert (result_o[DATA_W-1:HALF_W] == {HALF_W{chk_sign}}); // R9
        end
    end
endmodule

// File: tb/rsm_unit_bench.sv
`timescale 1ns/1ps
module rsm_unit_bench;

    localparam time CLK_HALF = 10ns;

    logic        clk = 1'b0;
    logic [63:0] src, ins;
    logic [6:0]  shamt;
    logic [31:0] insn;
    logic        word32, shr, arith, clr_left, clr_right, sext;
    logic [63:0] result;
    logic        carry;

    always #(CLK_HALF) clk = ~clk;

    rsm_unit u_rsm_unit (
        .src_i       (src),
        .ins_i       (ins),
        .shamt_i     (shamt),
        .insn_i      (insn),
        .word32_i    (word32),
        .shr_i       (shr),
        .arith_i     (arith),
        .clr_left_i  (clr_left),
        .clr_right_i (clr_right),
        .sext_i      (sext),
        .result_o    (result),
        .carry_o     (carry)
    );

    typedef struct {
        logic [63:0] res;
        logic        cy;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    function automatic logic [63:0] rotl(input logic [63:0] x, input int n);
        int k = n % 64;
        if (k == 0) return x;
        return (x << k) | (x >> (64 - k));
    endfunction

    function automatic logic [63:0] span(input int first, input int last);
        logic [63:0] a = 64'hFFFF_FFFF_FFFF_FFFF >> first;
        logic [63:0] b = 64'hFFFF_FFFF_FFFF_FFFF << (63 - last);
        return (first <= last) ? (a & b) : (a | b);
    endfunction

    function automatic logic [64:0] model(
        input logic [63:0] rs, input logic [63:0] ra, input logic [6:0] sh,
        input logic [31:0] iw, input logic w32, input logic r, input logic ar,
        input logic cl, input logic cr, input logic sx);
        logic [63:0] m, v, keep, res, sxv, lowm;
        logic        cy = 1'b0;
        logic        sg;
        int          a = int'(sh);
        int          b6 = int'({iw[5], iw[10:6]});
        int          mb5 = int'(iw[10:6]);
        int          me5 = int'(iw[5:1]);
        logic [63:0] s64 = sx ? {{32{rs[31]}}, rs[31:0]} : rs;
        if (cl || cr) begin
            if (w32 && cl && cr) begin
                v = rotl({rs[31:0], rs[31:0]}, int'(sh[4:0]));
                m = span(32 + mb5, 32 + me5);
            end else begin
                v = rotl(s64, int'(sh[5:0]));
                if (cl && !cr)      m = span(b6, 63);
                else if (!cl && cr) m = span(0, b6);
                else                m = span(b6, 63 - int'(sh[5:0]));
            end
            res = (v & m) | (ra & ~m);
        end else if (r && ar) begin
            sxv  = w32 ? {{32{rs[31]}}, rs[31:0]} : rs;
            sg   = w32 ? rs[31] : rs[63];
            res  = $signed(sxv) >>> ((a > 63) ? 63 : a);
            if (w32) lowm = (a >= 32) ? 64'hFFFF_FFFF : ((64'h1 << a) - 64'h1);
            else     lowm = (a >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'h1 << a) - 64'h1);
            cy = sg && ((rs & lowm) != 64'h0);
        end else begin
            if (!r) begin
                if (w32) begin
                    keep = (a >= 32) ? 64'h0 : ((64'hFFFF_FFFF << a) & 64'hFFFF_FFFF);
                    v    = {32'h0, rs[31:0]} << a;
                end else begin
                    keep = (a >= 64) ? 64'h0 : (64'hFFFF_FFFF_FFFF_FFFF << a);
                    v    = s64 << a;
                end
            end else begin
                if (w32) begin
                    keep = (a >= 32) ? 64'h0 : (64'hFFFF_FFFF >> a);
                    v    = {32'h0, rs[31:0]} >> a;
                end else begin
                    keep = (a >= 64) ? 64'h0 : (64'hFFFF_FFFF_FFFF_FFFF >> a);
                    v    = s64 >> a;
                end
            end
            res = (v & keep) | (ra & ~keep);
        end
        return {cy, res};
    endfunction

    task automatic apply(
        input logic [63:0] rs, input logic [63:0] ra, input logic [6:0] sh,
        input logic [31:0] iw, input logic w32, input logic r, input logic ar,
        input logic cl, input logic cr, input logic sx, input string tag);
        exp_t        e;
        logic [64:0] m;
        m = model(rs, ra, sh, iw, w32, r, ar, cl, cr, sx);
        @(posedge clk);
        #1;
        src = rs; ins = ra; shamt = sh; insn = iw;
        word32 = w32; shr = r; arith = ar; clr_left = cl; clr_right = cr; sext = sx;
        e.res = m[63:0];
        e.cy  = m[64];
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    always @(negedge clk) begin : monitor
        exp_t e;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            n_cmp++;
            if (result !== e.res || carry !== e.cy) begin
                n_bad++;
                $display("FAIL %s: got result=%h carry=%b, expected result=%h carry=%b",
                         e.tag, result, carry, e.res, e.cy);
            end
        end
    end

    function automatic logic [63:0] r64();
        return {$urandom(), $urandom()};
    endfunction

    function automatic logic [31:0] rinsn();
        logic [31:0] x = $urandom();
        return {21'h0, x[9:0], 1'b0};
    endfunction

    function automatic logic [31:0] fields(input int b, input int e);
        return {21'h0, 5'(b), 5'(e), 1'b0};
    endfunction

    task automatic report_out();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 2 * CLK_HALF);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): got hung run, expected completion");
            report_out();
        end
    end

    initial begin
        src = '0; ins = '0; shamt = '0; insn = '0;
        word32 = 0; shr = 0; arith = 0; clr_left = 0; clr_right = 0; sext = 0;

        apply(64'h0, 64'h0, 7'd0, 32'h0, 0, 0, 0, 0, 0, 0, "R7 idle zero");

        for (int i = 0; i < 150; i++)
            apply(r64(), 64'h0, 7'($urandom()), rinsn(), 1, 0, 0, 1, 1, 0, "R1 rot-mask32");
        apply(64'h0123_4567_89AB_CDEF, 64'h0, 7'd7, fields(20, 3), 1, 0, 0, 1, 1, 0, "R2 wrap32");
        apply(64'hFFFF_FFFF_0000_FFFF, 64'h0, 7'd0, fields(31, 0), 1, 0, 0, 1, 1, 0, "R2 wrap32 edge");
        for (int i = 0; i < 150; i++)
            apply(r64(), 64'h0, 7'($urandom()), rinsn(), 0, 0, 0, 1, 0, 0, "R3 keep-from");
        apply(r64(), 64'h0, 7'd5, fields(0, 0), 0, 0, 0, 1, 0, 0, "R3 begin0");
        apply(r64(), 64'h0, 7'd5, fields(31, 16), 0, 0, 0, 1, 0, 0, "R3 begin63");
        for (int i = 0; i < 150; i++)
            apply(r64(), 64'h0, 7'($urandom()), rinsn(), 0, 0, 0, 0, 1, 0, "R4 keep-upto");
        for (int i = 0; i < 150; i++)
            apply(r64(), 64'h0, 7'($urandom()), rinsn(), 0, 0, 0, 1, 1, 0, "R5 keep-mid");
        apply(r64(), 64'h0, 7'd0, fields(0, 0), 0, 0, 0, 1, 1, 0, "R5 shift0");
        apply(r64(), r64(), 7'd40, fields(31, 16), 0, 0, 0, 1, 1, 0, "R5 R2 wrap64 insert");
        for (int i = 0; i < 150; i++)
            apply(r64(), r64(), 7'($urandom()), rinsn(), 1, 0, 0, 1, 1, 0, "R6 insert32");
        for (int i = 0; i < 150; i++)
            apply(r64(), r64(), 7'($urandom()), rinsn(), 0, 0, 0, 1, 1, 0, "R6 insert64");
        apply(r64(), 64'hFFFF_FFFF_FFFF_FFFF, 7'd8, 32'h0, 0, 0, 0, 0, 0, 0, "R6 shift insert");

        for (int i = 0; i < 150; i++)
            apply(r64(), 64'h0, 7'($urandom()), 32'h0, 1, 0, 0, 0, 0, 0, "R7 shl32");
        for (int i = 0; i < 150; i++)
            apply(r64(), 64'h0, 7'($urandom()), 32'h0, 0, 0, 0, 0, 0, 0, "R7 shl64");
        apply(r64(), 64'h0, 7'd31, 32'h0, 1, 0, 0, 0, 0, 0, "R7 shl32 by31");
        apply(r64(), 64'h0, 7'd32, 32'h0, 1, 0, 0, 0, 0, 0, "R7 shl32 by32");
        apply(r64(), 64'h0, 7'd63, 32'h0, 0, 0, 0, 0, 0, 0, "R7 shl64 by63");
        apply(r64(), 64'h0, 7'd64, 32'h0, 0, 0, 0, 0, 0, 0, "R7 shl64 by64");
        apply(r64(), 64'h0, 7'd127, 32'h0, 0, 0, 0, 0, 0, 0, "R7 shl64 by127");

        for (int i = 0; i < 150; i++)
            apply(r64(), 64'h0, 7'($urandom()), 32'h0, 1, 1, 0, 0, 0, 0, "R8 shr32");
        for (int i = 0; i < 150; i++)
            apply(r64(), 64'h0, 7'($urandom()), 32'h0, 0, 1, 0, 0, 0, 0, "R8 shr64");
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 7'd32, 32'h0, 1, 1, 0, 0, 0, 0, "R8 shr32 by32");
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 7'd64, 32'h0, 0, 1, 0, 0, 0, 0, "R8 shr64 by64");

        for (int i = 0; i < 150; i++)
            apply(r64(), 64'h0, 7'($urandom() % 64), 32'h0, 1, 1, 1, 0, 0, 0, "R9 R10 sar32");
        for (int i = 0; i < 150; i++)
            apply(r64(), 64'h0, 7'($urandom()), 32'h0, 0, 1, 1, 0, 0, 0, "R9 R10 sar64");
        apply(64'h0000_0000_8000_0001, 64'h0, 7'd0, 32'h0, 1, 1, 1, 0, 0, 0, "R9 sar32 by0");
        apply(64'h0000_0000_8000_0001, 64'h0, 7'd32, 32'h0, 1, 1, 1, 0, 0, 0, "R9 R10 sar32 by32");
        apply(64'h8000_0000_0000_0000, 64'h0, 7'd100, 32'h0, 0, 1, 1, 0, 0, 0, "R9 sar64 by100");
        apply(64'hF000_0000_0000_0010, 64'h0, 7'd5, 32'h0, 0, 1, 1, 0, 0, 0, "R10 one lost");
        apply(64'hF000_0000_0000_0010, 64'h0, 7'd4, 32'h0, 0, 1, 1, 0, 0, 0, "R10 zeros lost");
        apply(64'h7000_0000_0000_00FF, 64'h0, 7'd8, 32'h0, 0, 1, 1, 0, 0, 0, "R10 positive");
        apply(64'hFFFF_FFFF_7FFF_FFFF, 64'h0, 7'd8, 32'h0, 1, 1, 1, 0, 0, 0, "R10 upper ignored");
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 7'd8, 32'h0, 0, 1, 0, 0, 0, 0, "R10 logical no carry");
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 7'd8, rinsn(), 0, 1, 1, 1, 1, 0, "R10 rotate no carry");

        for (int i = 0; i < 150; i++)
            apply(r64(), 64'h0, 7'($urandom() % 64), 32'h0, 0, 0, 0, 0, 0, 1, "R11 sext-shl");
        apply(64'h0000_0000_8000_0000, 64'h0, 7'd0, 32'h0, 0, 0, 0, 0, 0, 1, "R11 sext by0");
        apply(64'hFFFF_FFFF_7FFF_FFFF, 64'h0, 7'd4, 32'h0, 0, 0, 0, 0, 0, 1, "R11 sext positive");

        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        report_out();
    end
endmodule